// File: doc/BRIEF.md
# Dual-Rail Self-Timed Prefix Adder Pipeline

This block adds two 8-bit operands and a carry-in. It uses a parallel-prefix (Kogge-Stone) carry tree. Every signal inside it is carried on a pair of rails, so each logic function is produced together with its complement. The work is split over five token stages:

- The first stage forms per-bit generate, propagate and half-sum.
- Three prefix stages combine groups at distances 1, 2 and 4.
- The last stage forms the sum bits and the carry-out.

Stages pass tokens under a four-phase acknowledge protocol. A valid token is always followed by an all-empty token before the next valid one.

The token flow is modelled on a clock. A stage holding an empty token takes a complete token from upstream when its downstream acknowledge is low. A stage holding a valid token returns to empty when its downstream acknowledge is high and its upstream is empty. Each stage's acknowledge to upstream is high exactly while it holds a valid token.

Back-pressure comes from `out_ack`. While it stays low, the result stays in place and the pipeline behind it fills and then stops. A source must hold its operand rails until `in_ack` rises, and must hold them empty until `in_ack` falls. The `idle` output reports a pipeline holding only empty tokens.

Top module: `ks_dr_adder`

## Requirements
- R1: After reset every stage holds an empty token: `idle` is 1, `in_ack` is 0, and all sum and carry-out rails are 0.
- R2: Rail encoding: a bit equal to 1 has its true rail at 1 and its false rail at 0, and a bit equal to 0 is the reverse. An empty bit has both rails at 0. An input token is valid only when all 17 operand and carry-in pairs each have exactly one rail high.
- R3: For every valid result, `{cout, sum}` read from the true rails equals a + b + cin.
- R4: The output rails go back to all-empty between any two valid results. A valid result is never replaced directly by another one.
- R5: A stage loads a valid token only while its downstream acknowledge is low. It returns to empty only while that acknowledge is high.
- R6: With the pipeline empty and `out_ack` low, a valid input raises `in_ack` one clock edge later. The complete result appears on the output five clock edges after the input is applied, and not earlier.
- R7: While `out_ack` is low, a valid result on the output stays unchanged, even after the input has gone back to empty.
- R8: `idle` is 0 while any stage holds a valid token. It returns to 1 once the last result has been acknowledged and every stage has emptied.
- R9: An input that is partly empty and partly valid is not accepted, and neither is an input with a pair whose two rails are both high. In both cases `in_ack` stays 0 and `idle` stays 1.

Port directions below are relative to `ks_dr_adder`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the token registers |
| rst_n | input | 1 | Active-low reset; all stages go empty |
| a_t | input | 8 | Operand A, true rails |
| a_f | input | 8 | Operand A, false rails |
| b_t | input | 8 | Operand B, true rails |
| b_f | input | 8 | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| in_ack | output | 1 | Acknowledge to the source; high while the first stage holds a valid token |
| sum_t | output | 8 | Sum, true rails |
| sum_f | output | 8 | Sum, false rails |
| cout_t | output | 1 | Carry-out, true rail |
| cout_f | output | 1 | Carry-out, false rail |
| out_ack | input | 1 | Acknowledge from the sink |
| idle | output | 1 | High when every stage holds an empty token |

## Verification
The bench drives inputs just after a falling edge and samples just after the next falling edge. It therefore counts rising edges exactly. For a lone token in an empty pipeline with `out_ack` low, it expects `in_ack` after the first edge, an all-empty output after the fourth edge, and the complete result after the fifth. In streamed runs the result cannot be tied to a fixed cycle, because random source and sink delays stall the stages. There, each output token is matched by order against an integer sum computed in the bench. A free-running monitor, sampling 1 ns after each falling edge, checks that results never change while `out_ack` is low and always pass through empty.

// File: rtl/ks_dr_pkg.sv
package ks_dr_pkg;
  // One dual-rail bit: [1] true rail, [0] false rail. 00 means empty.
  typedef logic [1:0] dr_t;

  function automatic dr_t dr_and(dr_t x, dr_t y);
    return {x[1] & y[1], x[0] | y[0]};
  endfunction

  function automatic dr_t dr_or(dr_t x, dr_t y);
    return {x[1] | y[1], x[0] & y[0]};
  endfunction

  function automatic dr_t dr_xor(dr_t x, dr_t y);
    return {(x[1] & y[0]) | (x[0] & y[1]), (x[1] & y[1]) | (x[0] & y[0])};
  endfunction
endpackage

// File: rtl/ks_token_stage.sv
module ks_token_stage
  import ks_dr_pkg::*;
#(
  parameter int NP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dr_t [NP-1:0]  in_d,
  input  logic          nxt_ack,
  output dr_t [NP-1:0]  out_d,
  output logic          full
);
  dr_t [NP-1:0] d_q;
  logic in_full, in_empty, q_empty;

  always_comb begin
    in_full  = 1'b1;
    in_empty = 1'b1;
    full     = 1'b1;
    q_empty  = 1'b1;
    for (int i = 0; i < NP; i++) begin
      in_full  &= ^in_d[i];
      in_empty &= ~|in_d[i];
      full     &= ^d_q[i];
      q_empty  &= ~|d_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      d_q <= '0;
    else if (!nxt_ack && in_full && q_empty)
      d_q <= in_d;
    else if (nxt_ack && in_empty && full)
      d_q <= '0;
  end

  assign out_d = d_q;

  // R4
  token_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full || q_empty);

  // R5
  fill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> !$past(nxt_ack));

  // R5
  drain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(nxt_ack));

  // R7
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && $past(full)) |-> $stable(d_q));
endmodule

// File: rtl/ks_prefix_level.sv
module ks_prefix_level
  import ks_dr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SPAN  = 1
) (
  input  dr_t [WIDTH-1:0] g_i,
  input  dr_t [WIDTH-1:0] p_i,
  output dr_t [WIDTH-1:0] g_o,
  output dr_t [WIDTH-1:0] p_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i >= SPAN) begin : g_comb
      assign g_o[i] = dr_or(g_i[i], dr_and(p_i[i], g_i[i-SPAN]));
      assign p_o[i] = dr_and(p_i[i], p_i[i-SPAN]);
    end else begin : g_pass
      assign g_o[i] = g_i[i];
      assign p_o[i] = p_i[i];
    end
  end
endmodule

// File: rtl/ks_sum_form.sv
module ks_sum_form
  import ks_dr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  dr_t [WIDTH-1:0] grp_g,
  input  dr_t [WIDTH-1:0] grp_p,
  input  dr_t [WIDTH-1:0] half,
  input  dr_t             cin,
  output dr_t [WIDTH:0]   res
);
  dr_t [WIDTH-1:0] carry;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign carry[i] = dr_or(grp_g[i], dr_and(grp_p[i], cin));
    if (i == 0) begin : g_lsb
      assign res[i] = dr_xor(half[i], cin);
    end else begin : g_upper
      assign res[i] = dr_xor(half[i], carry[i-1]);
    end
  end
  assign res[WIDTH] = carry[WIDTH-1];
endmodule

// File: rtl/ks_dr_adder.sv
module ks_dr_adder
  import ks_dr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_t,
  input  logic [WIDTH-1:0] a_f,
  input  logic [WIDTH-1:0] b_t,
  input  logic [WIDTH-1:0] b_f,
  input  logic             cin_t,
  input  logic             cin_f,
  output logic             in_ack,
  output logic [WIDTH-1:0] sum_t,
  output logic [WIDTH-1:0] sum_f,
  output logic             cout_t,
  output logic             cout_f,
  input  logic             out_ack,
  output logic             idle
);
  localparam int LEVELS = $clog2(WIDTH);
  localparam int STAGES = LEVELS + 2;
  localparam int NP     = 3 * WIDTH + 1;  // g | p | half-sum | carry-in
  localparam int NS     = WIDTH + 1;      // sum | carry-out
  localparam int P_LO   = WIDTH;
  localparam int X_LO   = 2 * WIDTH;

  dr_t [NP-1:0]   gen_d;
  dr_t [NP-1:0]   lvl_q [0:LEVELS];
  dr_t [NS-1:0]   sum_d;
  dr_t [NS-1:0]   res_q;
  logic [STAGES-1:0] st_full;

  // Bitwise generate / propagate / half-sum
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      gen_d[i]        = dr_and({a_t[i], a_f[i]}, {b_t[i], b_f[i]});
      gen_d[P_LO + i] = dr_xor({a_t[i], a_f[i]}, {b_t[i], b_f[i]});
      gen_d[X_LO + i] = dr_xor({a_t[i], a_f[i]}, {b_t[i], b_f[i]});
    end
    gen_d[NP-1] = {cin_t, cin_f};
  end

  ks_token_stage #(.NP(NP)) u_gen (
    .clk(clk), .rst_n(rst_n), .in_d(gen_d), .nxt_ack(st_full[1]),
    .out_d(lvl_q[0]), .full(st_full[0])
  );

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    dr_t [NP-1:0] nx;
    ks_prefix_level #(.WIDTH(WIDTH), .SPAN(1 << lv)) u_pf (
      .g_i(lvl_q[lv][WIDTH-1:0]),
      .p_i(lvl_q[lv][X_LO-1:P_LO]),
      .g_o(nx[WIDTH-1:0]),
      .p_o(nx[X_LO-1:P_LO])
    );
    assign nx[NP-1:X_LO] = lvl_q[lv][NP-1:X_LO];
    ks_token_stage #(.NP(NP)) u_st (
      .clk(clk), .rst_n(rst_n), .in_d(nx), .nxt_ack(st_full[lv+2]),
      .out_d(lvl_q[lv+1]), .full(st_full[lv+1])
    );
  end

  ks_sum_form #(.WIDTH(WIDTH)) u_sum (
    .grp_g(lvl_q[LEVELS][WIDTH-1:0]),
    .grp_p(lvl_q[LEVELS][X_LO-1:P_LO]),
    .half(lvl_q[LEVELS][NP-2:X_LO]),
    .cin(lvl_q[LEVELS][NP-1]),
    .res(sum_d)
  );

  ks_token_stage #(.NP(NS)) u_out (
    .clk(clk), .rst_n(rst_n), .in_d(sum_d), .nxt_ack(out_ack),
    .out_d(res_q), .full(st_full[STAGES-1])
  );

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      sum_t[i] = res_q[i][1];
      sum_f[i] = res_q[i][0];
    end
    cout_t = res_q[WIDTH][1];
    cout_f = res_q[WIDTH][0];
  end

  assign in_ack = st_full[0];
  assign idle   = ~|st_full;

  logic in_cmp;
  assign in_cmp = (&(a_t ^ a_f)) && (&(b_t ^ b_f)) && (cin_t ^ cin_f);

  // R8
  idle_outputs_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (sum_t == '0 && sum_f == '0 && !cout_t && !cout_f));

  // R9
  accept_only_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_cmp));
endmodule

// File: tb/ks_dr_adder_test.sv
module ks_dr_adder_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
  logic cin_t = 1'b0, cin_f = 1'b0;
  logic out_ack = 1'b0;
  logic in_ack, cout_t, cout_f, idle;
  logic [W-1:0] sum_t, sum_f;

  always #4 clk = ~clk;

  ks_dr_adder #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .cin_t(cin_t), .cin_f(cin_f), .in_ack(in_ack), .sum_t(sum_t),
    .sum_f(sum_f), .cout_t(cout_t), .cout_f(cout_f), .out_ack(out_ack),
    .idle(idle)
  );

  int checks = 0;
  int fails = 0;
  int mon_r4 = 0;
  int mon_r7 = 0;
  bit done = 1'b0;

  wire out_cmp = (&(sum_t ^ sum_f)) & (cout_t ^ cout_f);
  wire out_emp = ~|{sum_t, sum_f, cout_t, cout_f};

  // {a, b, cin, expected 9-bit result}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0, 9'h000},
    {8'h00, 8'h00, 1'b1, 9'h001},
    {8'hFF, 8'h00, 1'b1, 9'h100},
    {8'hFF, 8'hFF, 1'b1, 9'h1FF},
    {8'hFF, 8'hFF, 1'b0, 9'h1FE},
    {8'h80, 8'h80, 1'b0, 9'h100},
    {8'h55, 8'hAA, 1'b0, 9'h0FF},
    {8'h55, 8'hAA, 1'b1, 9'h100},
    {8'h0F, 8'h01, 1'b0, 9'h010},
    {8'h7F, 8'h01, 1'b0, 9'h080},
    {8'h12, 8'h34, 1'b1, 9'h047},
    {8'hC8, 8'h64, 1'b0, 9'h12C}
  };

  localparam int NR = 200;
  logic [7:0] sa [NR];
  logic [7:0] sb [NR];
  logic       sc [NR];
  logic [8:0] se [NR];
  int n_tok;
  bit rand_dly;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic c);
    a_t = a; a_f = ~a; b_t = b; b_f = ~b; cin_t = c; cin_f = ~c;
  endtask

  task automatic drive_empty();
    a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
  endtask

  task automatic pause();
    int d;
    d = rand_dly ? int'($urandom_range(0, 3)) : 0;
    repeat (d) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] b, input logic c);
    @(negedge clk);
    drive(a, b, c);
    do @(negedge clk); while (!in_ack);
    pause();
    drive_empty();
    do @(negedge clk); while (in_ack);
    pause();
  endtask

  task automatic recv(output logic [8:0] v);
    do @(negedge clk); while (!out_cmp);
    v = {cout_t, sum_t};
    pause();
    out_ack = 1'b1;
    do @(negedge clk); while (!out_emp);
    pause();
    out_ack = 1'b0;
  endtask

  task automatic run_stream();
    fork
      begin
        for (int i = 0; i < n_tok; i++) send(sa[i], sb[i], sc[i]);
      end
      begin
        for (int i = 0; i < n_tok; i++) begin
          logic [8:0] v;
          recv(v);
          // R3 sum against integer model
          chk(v == se[i], "R3 result", {23'd0, v}, {23'd0, se[i]});
        end
      end
    join
  endtask

  // Output token discipline monitor (R4, R7), sampled 1 ns after falling edge
  logic prev_cmp = 1'b0, prev_ack = 1'b0;
  logic [17:0] prev_raw = '0;
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (prev_cmp && out_cmp && ({cout_t, cout_f, sum_t, sum_f} != prev_raw))
        mon_r4++;
      if (prev_cmp && !prev_ack && ({cout_t, cout_f, sum_t, sum_f} != prev_raw))
        mon_r7++;
    end
    prev_cmp = out_cmp;
    prev_ack = out_ack;
    prev_raw = {cout_t, cout_f, sum_t, sum_f};
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(idle == 1'b1, "R1 idle", idle, 1);
    chk(in_ack == 1'b0, "R1 in_ack", in_ack, 0);
    chk(out_emp == 1'b1, "R1 output rails", {cout_t, cout_f, sum_t, sum_f}, 0);

    // R9 partially valid input is not taken
    a_t = 8'h01;
    repeat (6) @(negedge clk);
    chk(in_ack == 1'b0 && idle == 1'b1, "R9 partial input", {in_ack, idle}, 2'b01);
    // R9 pairs with both rails high are not taken
    a_t = '1; a_f = '1; b_t = '1; b_f = '1; cin_t = 1'b1; cin_f = 1'b1;
    repeat (6) @(negedge clk);
    chk(in_ack == 1'b0 && idle == 1'b1, "R9 double-high input", {in_ack, idle}, 2'b01);
    drive_empty();
    repeat (2) @(negedge clk);

    // R6 latency of a lone token, R2 encoding of a valid token
    drive(8'h3C, 8'h5A, 1'b1);
    @(negedge clk);
    chk(in_ack == 1'b1, "R6 R2 in_ack after one edge", in_ack, 1);
    repeat (3) @(negedge clk);
    chk(out_emp == 1'b1, "R6 output empty after four edges", out_cmp, 0);
    @(negedge clk);
    chk(out_cmp == 1'b1, "R6 result after five edges", out_cmp, 1);
    chk({cout_t, sum_t} == 9'h097, "R3 R2 lone token value", {cout_t, sum_t}, 9'h097);
    chk({cout_f, sum_f} == ~9'h097, "R2 false rails", {cout_f, sum_f}, ~9'h097);
    drive_empty();
    // R7 result held while out_ack low
    repeat (10) @(negedge clk);
    chk(out_cmp && {cout_t, sum_t} == 9'h097, "R7 hold under back-pressure",
        {cout_t, sum_t}, 9'h097);
    chk(idle == 1'b0, "R8 busy while result held", idle, 0);
    out_ack = 1'b1;
    do @(negedge clk); while (!out_emp);
    out_ack = 1'b0;
    repeat (2) @(negedge clk);
    chk(idle == 1'b1, "R8 idle after drain", idle, 1);

    // Table of vectors, back-to-back, no extra delays
    rand_dly = 1'b0;
    n_tok = NV;
    for (int i = 0; i < NV; i++) begin
      sa[i] = VEC[i][25:18];
      sb[i] = VEC[i][17:10];
      sc[i] = VEC[i][9];
      se[i] = VEC[i][8:0];
    end
    run_stream();

    // Random operands with random handshake delays
    rand_dly = 1'b1;
    n_tok = NR;
    for (int i = 0; i < NR; i++) begin
      sa[i] = 8'($urandom);
      sb[i] = 8'($urandom);
      sc[i] = 1'($urandom);
      se[i] = {1'b0, sa[i]} + {1'b0, sb[i]} + {8'd0, sc[i]};
    end
    run_stream();

    // Carry-in corner with held back-pressure
    rand_dly = 1'b0;
    fork
      send(8'hFF, 8'h00, 1'b1);
      begin
        do @(negedge clk); while (!out_cmp);
        repeat (5) @(negedge clk);
        v = {cout_t, sum_t};
        chk(v == 9'h100, "R3 R7 carry-in ripple held", v, 9'h100);
        out_ack = 1'b1;
        do @(negedge clk); while (!out_emp);
        out_ack = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    chk(idle == 1'b1, "R8 idle at end", idle, 1);

    chk(mon_r4 == 0, "R4 result changed without empty", mon_r4, 0);
    chk(mon_r7 == 0, "R7 result changed while out_ack low", mon_r7, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule